// File: doc/BRIEF.md
# CAN Transceiver Local and Bus Fault Monitor

This block sits between the digital side of a high-speed CAN transceiver and its analog front end. It watches the transmit and receive data lines together with digital indications from the analog comparators: bus dominant, bus short, over-temperature and a transmit-to-receive pin short. From these it works out whether the transmitter may drive the bus. It keeps a local failure flag and a bus failure flag, and it drives an active-low error line whose meaning depends on the operating mode that the mode controller supplies.

Local faults are caught in normal and listen-only mode. A stuck dominant transmit line, a receive line stuck recessive while the bus is dominant, a pin short and overheating all block the transmitter. The block stays latched until the flag is cleared with every cause resolved. A bus held dominant for too long only raises the flag, and only for as long as the bus stays dominant. A bus short seen on several consecutive transmitted dominant bits in a row raises the bus failure flag. In normal mode the error line first reports the wake-up source flag and then reports bus failure, once enough transmit bits have ended.

Top module: `xcvr_fault_mon`

## Requirements
- R1: With transmit data low (dominant) for more than TXD_TO_CYC synchronised cycles in normal or listen-only mode, the local failure flag is set and the transmitter enable drops. Both stay that way after transmit data returns high.
- R2: With the bus dominant indication high while receive data is high (recessive) in normal or listen-only mode, the local failure flag is set and the transmitter enable drops. Both stay that way after the condition ends.
- R3: With the bus dominant indication high for more than BUS_TO_CYC synchronised cycles, the local failure flag is raised while the transmitter stays enabled. The flag falls again within four cycles of the bus indication going low.
- R4: An over-temperature or transmit-to-receive short indication in normal or listen-only mode sets the local failure flag and drops the transmitter enable. These stay latched until the flag is cleared.
- R5: The latched local failure clears on entry to normal mode, or when receive data is low while transmit data is high. It clears only if no latching cause is still present at that moment.
- R6: A dominant-to-recessive transition of transmit data (a rising edge) closes a dominant bit. The bus failure flag is set in normal mode when SHORT_RUNS consecutive dominant bits, each with the bus short indication seen while the transmitter was enabled, end this way. A dominant bit with no short resets the run. The flag holds in every mode until normal mode is entered again.
- R7: In normal mode the error output equals the inverted wake-up source input until EDGE_LIMIT rising edges of transmit data have been counted. After that it equals the inverted bus failure flag. The edge count restarts on each entry to normal mode.
- R8: In listen-only mode reached directly from normal mode, the error output equals the inverted local failure flag. In listen-only mode reached from any other mode the error output is high.
- R9: Mode codes are 0 normal, 1 listen-only, 2 standby, 3 go-to-sleep, 4 sleep. The transmitter enable is high only in normal mode. In standby, go-to-sleep and sleep no fault is recorded and the error output is high.
- R10: After reset, with standby mode applied, the transmitter enable, the local failure flag and the bus failure flag are low and the error output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txd_i | input | 1 | Transmit data from the protocol controller, low = dominant |
| rxd_i | input | 1 | Receive data as driven to the controller, low = dominant |
| bus_dom_i | input | 1 | Bus differential comparator, high = dominant |
| bus_short_i | input | 1 | Bus short-circuit comparator, high = short seen |
| overtemp_i | input | 1 | Over-temperature indication |
| txrx_short_i | input | 1 | Transmit-to-receive pin short indication |
| mode_i | input | 3 | Operating mode from the mode controller |
| wake_src_i | input | 1 | Wake-up source flag from the wake-up logic |
| tx_en_o | output | 1 | Transmitter enable |
| local_fail_o | output | 1 | Local failure flag |
| bus_fail_o | output | 1 | Bus failure flag |
| err_n_o | output | 1 | Active-low error output |

## Verification
A wrong fault latch shows within a few cycles as a transmitter enable that comes back too early or stays off after a valid clear. It also shows in the local failure flag, which stays high when receive data goes dominant with transmit data recessive. A miscounting bus-short run or edge counter can only be seen at the fourth transmitted bit end, where the bus failure flag or the error output takes the wrong value. Mode-history faults show at the first cycle of listen-only mode, as an error output that does not track the local failure flag.

// File: rtl/xfm_pkg.sv
package xfm_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL  = 3'd0,
    MODE_LISTEN  = 3'd1,
    MODE_STANDBY = 3'd2,
    MODE_GOSLEEP = 3'd3,
    MODE_SLEEP   = 3'd4
  } op_mode_e;

  localparam int unsigned SYNC_W = 4;
  localparam int unsigned SYN_TXD = 0;
  localparam int unsigned SYN_RXD = 1;
  localparam int unsigned SYN_BDOM = 2;
  localparam int unsigned SYN_BSHORT = 3;

endpackage

// File: rtl/xfm_sync.sv
module xfm_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/xfm_dwell_timer.sv
module xfm_dwell_timer #(
  parameter int unsigned LIMIT = 9600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic hit_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!level_i) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q != LIM) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = (cnt_q == LIM);

endmodule

// File: rtl/xfm_local_fail.sv
module xfm_local_fail (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic txd_to_i,
  input  logic rxd_clamp_i,
  input  logic overtemp_i,
  input  logic txrx_short_i,
  input  logic bus_to_i,
  input  logic clear_evt_i,
  output logic block_o,
  output logic flag_o
);

  logic cause_now;
  logic set_evt;
  logic latch_q, latch_d, latch_en;

  assign cause_now = txd_to_i | rxd_clamp_i | overtemp_i | txrx_short_i;
  assign set_evt   = active_i & cause_now;

  always_comb begin
    latch_en = 1'b0;
    latch_d  = latch_q;
    if (set_evt) begin
      latch_en = 1'b1;
      latch_d  = 1'b1;
    end else if (clear_evt_i && !cause_now) begin
      latch_en = 1'b1;
      latch_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b0;
    else if (latch_en) latch_q <= latch_d;
  end

  assign block_o = latch_q;
  assign flag_o  = latch_q | (active_i & bus_to_i);

endmodule

// File: rtl/xfm_txd_edges.sv
module xfm_txd_edges #(
  parameter int unsigned EDGE_LIMIT = 4,
  parameter int unsigned SHORT_RUNS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic txd_s_i,
  input  logic bus_short_s_i,
  input  logic normal_i,
  input  logic drive_i,
  input  logic restart_i,
  output logic edges_done_o,
  output logic bus_fail_o
);

  localparam int unsigned ECW = $clog2(EDGE_LIMIT + 1);
  localparam int unsigned SCW = $clog2(SHORT_RUNS + 1);
  localparam logic [ECW-1:0] E_MAX = ECW'(EDGE_LIMIT);
  localparam logic [SCW-1:0] S_MAX = SCW'(SHORT_RUNS);
  localparam logic [SCW-1:0] S_LAST = SCW'(SHORT_RUNS - 1);

  logic           txd_prev_q;
  logic           rise;
  logic [ECW-1:0] edge_q, edge_d;
  logic [SCW-1:0] run_q, run_d;
  logic           seen_q, seen_d;
  logic           fail_q, fail_d;

  assign rise = txd_s_i & ~txd_prev_q;

  always_comb begin
    edge_d = edge_q;
    run_d  = run_q;
    seen_d = seen_q;
    fail_d = fail_q;
    if (restart_i) begin
      edge_d = '0;
      run_d  = '0;
      seen_d = 1'b0;
      fail_d = 1'b0;
    end else if (rise) begin
      seen_d = 1'b0;
      if (normal_i) begin
        if (edge_q != E_MAX) edge_d = edge_q + 1'b1;
        if (!seen_q)             run_d = '0;
        else if (run_q != S_MAX) run_d = run_q + 1'b1;
        if (seen_q && run_q == S_LAST) fail_d = 1'b1;
      end
    end else if (normal_i && drive_i && !txd_s_i && bus_short_s_i) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_prev_q <= 1'b1;
      edge_q     <= '0;
      run_q      <= '0;
      seen_q     <= 1'b0;
      fail_q     <= 1'b0;
    end else begin
      txd_prev_q <= txd_s_i;
      edge_q     <= edge_d;
      run_q      <= run_d;
      seen_q     <= seen_d;
      fail_q     <= fail_d;
    end
  end

  assign edges_done_o = (edge_q == E_MAX);
  assign bus_fail_o   = fail_q;

endmodule

// File: rtl/xcvr_fault_mon.sv
module xcvr_fault_mon
  import xfm_pkg::*;
#(
  parameter int unsigned TXD_TO_CYC  = 9600,
  parameter int unsigned BUS_TO_CYC  = 9600,
  parameter int unsigned EDGE_LIMIT  = 4,
  parameter int unsigned SHORT_RUNS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd_i,
  input  logic       rxd_i,
  input  logic       bus_dom_i,
  input  logic       bus_short_i,
  input  logic       overtemp_i,
  input  logic       txrx_short_i,
  input  logic [2:0] mode_i,
  input  logic       wake_src_i,
  output logic       tx_en_o,
  output logic       local_fail_o,
  output logic       bus_fail_o,
  output logic       err_n_o
);

  localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(4'b0011);

  logic [SYNC_W-1:0] raw_vec, syn_vec;
  logic txd_s, rxd_s, bdom_s, bshort_s;

  assign raw_vec[SYN_TXD]    = txd_i;
  assign raw_vec[SYN_RXD]    = rxd_i;
  assign raw_vec[SYN_BDOM]   = bus_dom_i;
  assign raw_vec[SYN_BSHORT] = bus_short_i;

  xfm_sync #(
    .WIDTH  (SYNC_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_vec),
    .q_o  (syn_vec)
  );

  assign txd_s    = syn_vec[SYN_TXD];
  assign rxd_s    = syn_vec[SYN_RXD];
  assign bdom_s   = syn_vec[SYN_BDOM];
  assign bshort_s = syn_vec[SYN_BSHORT];

  // Mode history
  logic [2:0] mode_q;
  logic       from_normal_q, from_normal_d;
  logic       is_normal, is_listen, active, enter_normal;

  assign is_normal    = (mode_i == MODE_NORMAL);
  assign is_listen    = (mode_i == MODE_LISTEN);
  assign active       = is_normal | is_listen;
  assign enter_normal = is_normal & (mode_q != MODE_NORMAL);

  always_comb begin
    from_normal_d = 1'b0;
    if (is_normal)      from_normal_d = 1'b1;
    else if (is_listen) from_normal_d = from_normal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= MODE_STANDBY;
      from_normal_q <= 1'b0;
    end else begin
      mode_q        <= mode_i;
      from_normal_q <= from_normal_d;
    end
  end

  // Dominant dwell timers
  logic txd_to_hit, bus_to_hit;

  xfm_dwell_timer #(.LIMIT(TXD_TO_CYC)) u_txd_to (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(~txd_s),
    .hit_o  (txd_to_hit)
  );

  xfm_dwell_timer #(.LIMIT(BUS_TO_CYC)) u_bus_to (
    .clk    (clk),
    .rst_n  (rst_n),
    .level_i(bdom_s),
    .hit_o  (bus_to_hit)
  );

  // Local failure handling
  logic rxd_clamp, clear_evt, tx_block;

  assign rxd_clamp = bdom_s & rxd_s;
  assign clear_evt = enter_normal | (~rxd_s & txd_s);

  xfm_local_fail u_local (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (active),
    .txd_to_i    (txd_to_hit),
    .rxd_clamp_i (rxd_clamp),
    .overtemp_i  (overtemp_i),
    .txrx_short_i(txrx_short_i),
    .bus_to_i    (bus_to_hit),
    .clear_evt_i (clear_evt),
    .block_o     (tx_block),
    .flag_o      (local_fail_o)
  );

  assign tx_en_o = is_normal & ~tx_block;

  // Transmit edge counting and bus short qualification
  logic edges_done;

  xfm_txd_edges #(
    .EDGE_LIMIT(EDGE_LIMIT),
    .SHORT_RUNS(SHORT_RUNS)
  ) u_edges (
    .clk          (clk),
    .rst_n        (rst_n),
    .txd_s_i      (txd_s),
    .bus_short_s_i(bshort_s),
    .normal_i     (is_normal),
    .drive_i      (tx_en_o),
    .restart_i    (enter_normal),
    .edges_done_o (edges_done),
    .bus_fail_o   (bus_fail_o)
  );

  // Error output selection
  always_comb begin
    err_n_o = 1'b1;
    if (is_normal)      err_n_o = edges_done ? ~bus_fail_o : ~wake_src_i;
    else if (is_listen) err_n_o = from_normal_q ? ~local_fail_o : 1'b1;
  end

endmodule

// File: rtl/xcvr_fault_mon_chk.sv
module xcvr_fault_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_i,
  input logic       overtemp_i,
  input logic       txrx_short_i,
  input logic       tx_en_o,
  input logic       local_fail_o,
  input logic       bus_fail_o,
  input logic       err_n_o,
  input logic       txd_to_hit,
  input logic       enter_normal
);

  // R1: a dominant timeout in normal mode blocks the transmitter next cycle
  p_txd_timeout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 && txd_to_hit) |=> (!tx_en_o && local_fail_o));

  // R4: overheating or a pin short in normal mode blocks the transmitter
  p_fault_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd0 && (overtemp_i || txrx_short_i)) |=> !tx_en_o);

  // R6: the bus failure flag only rises out of normal mode operation
  p_bf_from_normal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_fail_o) |-> $past(mode_i) == 3'd0);

  // R6: once set the bus failure flag holds until normal mode is re-entered
  p_bf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_fail_o && !enter_normal) |=> bus_fail_o);

  // R8: listen-only straight after normal mode reports the local failure flag
  p_err_listen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'd1 && $past(mode_i) == 3'd0) |-> (err_n_o == !local_fail_o));

endmodule

bind xcvr_fault_mon xcvr_fault_mon_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .overtemp_i  (overtemp_i),
  .txrx_short_i(txrx_short_i),
  .tx_en_o     (tx_en_o),
  .local_fail_o(local_fail_o),
  .bus_fail_o  (bus_fail_o),
  .err_n_o     (err_n_o),
  .txd_to_hit  (txd_to_hit),
  .enter_normal(enter_normal)
);

// File: tb/xcvr_fault_mon_bench.sv
module xcvr_fault_mon_bench;

  localparam int TO_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, rxd = 1'b1, bdom = 1'b0, bshort = 1'b0;
  logic otemp = 1'b0, tshort = 1'b0, wake = 1'b0;
  logic [2:0] mode = 3'd2;
  logic tx_en, lf, bf, err_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  xcvr_fault_mon #(
    .TXD_TO_CYC(TO_CYC),
    .BUS_TO_CYC(TO_CYC)
  ) u_xcvr_fault_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd_i       (txd),
    .rxd_i       (rxd),
    .bus_dom_i   (bdom),
    .bus_short_i (bshort),
    .overtemp_i  (otemp),
    .txrx_short_i(tshort),
    .mode_i      (mode),
    .wake_src_i  (wake),
    .tx_en_o     (tx_en),
    .local_fail_o(lf),
    .bus_fail_o  (bf),
    .err_n_o     (err_n)
  );

  // Row layout: txd rxd bdom bshort otemp tshort | mode | wake | hold |
  //             exp tx_en lf bf err_n | requirement number
  typedef struct packed {
    logic       txd, rxd, bdom, bshort, otemp, tshort;
    logic [2:0] mode;
    logic       wake;
    logic [7:0] hold;
    logic       e_tx, e_lf, e_bf, e_err;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    26'b110000_000_1_00000110_1000_0111, // R7 normal, wake source shown
    26'b110000_000_0_00000100_1001_0111, // R7 wake source cleared
    26'b110010_000_0_00000100_0101_0100, // R4 over-temperature
    26'b110000_000_0_00000100_0101_0100, // R4 stays latched
    26'b100000_000_0_00000100_1001_0101, // R5 clear via rxd dom, txd rec
    26'b110000_000_0_00000100_1001_0101, // R5 stays clear
    26'b000000_000_0_00001000_1001_0001, // R1 txd low, below timeout
    26'b000000_000_0_00010100_0101_0001, // R1 txd timeout
    26'b110000_000_0_00000100_0101_0001, // R1 latched after release
    26'b100000_000_0_00000100_1001_0101, // R5 clear
    26'b111000_000_0_00000100_0101_0010, // R2 rxd recessive clamp
    26'b110000_000_0_00000100_0101_0010, // R2 latched
    26'b100000_000_0_00000100_1001_0101, // R5 clear
    26'b110010_000_0_00000100_0101_0100, // R4 over-temperature again
    26'b100010_000_0_00000100_0101_0101, // R5 clear blocked while unresolved
    26'b100000_000_0_00000100_1001_0101, // R5 clear once resolved
    26'b110001_000_1_00000100_0100_0100, // R4 pin short
    26'b110000_001_1_00000100_0100_1000, // R8 listen from normal
    26'b110000_000_1_00000100_1000_0101, // R5 normal entry clears
    26'b101000_000_0_00001000_1001_0011, // R3 bus dominant, below timeout
    26'b101000_000_0_00010100_1101_0011, // R3 bus timeout, tx kept
    26'b110000_000_0_00000100_1001_0011, // R3 released
    26'b110000_010_0_00000100_0001_1001, // R9 standby
    26'b110010_010_0_00000100_0001_1001, // R9 fault ignored in standby
    26'b110010_001_0_00000100_0101_1000, // R8 listen from standby
    26'b110000_000_0_00000100_1001_0101  // R5 entry clears
  };

  vec_t cur;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic e_tx, input logic e_lf,
                         input logic e_bf, input logic e_err);
    chk(req, "tx_en", tx_en, e_tx);
    chk(req, "local_fail", lf, e_lf);
    chk(req, "bus_fail", bf, e_bf);
    chk(req, "err_n", err_n, e_err);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One transmitted dominant bit followed by a recessive gap
  task automatic dom_bit(input logic shrt);
    txd = 1'b0; rxd = 1'b0; bdom = 1'b1; bshort = shrt;
    wait_cyc(4);
    txd = 1'b1; rxd = 1'b1; bdom = 1'b0; bshort = 1'b0;
    wait_cyc(4);
  endtask

  task automatic set_mode(input logic [2:0] m, input int n);
    mode = m;
    wait_cyc(n);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R10 reset state
    chk_all("R10", 1'b0, 1'b0, 1'b0, 1'b1);

    for (int i = 0; i < NV; i++) begin
      cur = VECS[i];
      txd = cur.txd; rxd = cur.rxd; bdom = cur.bdom; bshort = cur.bshort;
      otemp = cur.otemp; tshort = cur.tshort; mode = cur.mode; wake = cur.wake;
      wait_cyc(int'(cur.hold));
      chk_all($sformatf("R%0d row%0d", cur.req, i), cur.e_tx, cur.e_lf, cur.e_bf, cur.e_err);
    end

    // R7 four clean bits: wake source shown, then bus failure (clear)
    wake = 1'b1;
    for (int b = 0; b < 3; b++) dom_bit(1'b0);
    chk("R7", "err_n before 4th edge", err_n, 1'b0);
    dom_bit(1'b0);
    chk("R7", "err_n after 4th edge", err_n, 1'b1);
    chk("R6", "bus_fail clean bits", bf, 1'b0);

    // R7 edge count restarts on normal entry
    set_mode(3'd1, 4);
    set_mode(3'd0, 4);
    chk("R7", "err_n after restart", err_n, 1'b0);

    // R6 four consecutive shorted bits
    wake = 1'b0;
    wait_cyc(2);
    for (int b = 0; b < 3; b++) dom_bit(1'b1);
    chk("R6", "bus_fail after 3 runs", bf, 1'b0);
    chk("R7", "err_n before 4th edge", err_n, 1'b1);
    dom_bit(1'b1);
    chk("R6", "bus_fail after 4 runs", bf, 1'b1);
    chk("R7", "err_n shows bus fail", err_n, 1'b0);
    chk("R6", "tx_en kept", tx_en, 1'b1);

    // R6 flag holds outside normal, clears on re-entry
    set_mode(3'd1, 4);
    chk("R6", "bus_fail held in listen", bf, 1'b1);
    chk("R8", "err_n listen no local fault", err_n, 1'b1);
    set_mode(3'd0, 4);
    chk("R6", "bus_fail cleared on entry", bf, 1'b0);

    // R6 run broken by a clean bit
    for (int b = 0; b < 3; b++) dom_bit(1'b1);
    dom_bit(1'b0);
    dom_bit(1'b1);
    chk("R6", "bus_fail broken run", bf, 1'b0);
    for (int b = 0; b < 3; b++) dom_bit(1'b1);
    chk("R6", "bus_fail new run of 4", bf, 1'b1);

    finish_run();
  end

endmodule